// File: doc/BRIEF.md
# Multicast Hash Receive Address Filter

This block sits beside a receive MAC. It watches the first bytes of each incoming frame and decides whether the frame passes the group-address hash filter. The destination address arrives one byte per cycle, and a start marker flags the first byte. The block runs a reflected CRC-32 across those address bytes. Six bits of the result pick one bit out of a 64-bit mask, which software loads as four 16-bit words. Exact matching of station (unicast) addresses happens elsewhere. For frames that are not group frames, this filter only gives a verdict when promiscuous reception is on.

Software first drops the receive enable. It then rewrites the mask words and raises the enable again. While the receiver is enabled the mask is locked, and incoming bytes are only looked at while it is enabled. Three configuration bits select the policy:

- a hash-filter enable;
- an all-multicast bit, which makes the mask behave as all ones;
- a promiscuous bit, which passes every frame.

The verdict is registered. It appears on the clock edge that takes the last address byte and stays put until the next start marker.

A small state machine drives the flow. It has three states:

| State | Meaning |
|---|---|
| `ST_IDLE` | Waiting for a start byte. |
| `ST_ADDR` | Gathering address bytes. |
| `ST_HELD` | Verdict published. |

Its transitions are:

| Transition | From | To | Condition |
|---|---|---|---|
| `T_START` | `ST_IDLE` | `ST_ADDR` | A start byte arrives. |
| `T_RESTART` | `ST_ADDR` | `ST_ADDR` | A start byte arrives mid-address. |
| `T_ABORT` | `ST_ADDR` | `ST_IDLE` | The receive enable drops. |
| `T_DECIDE` | `ST_ADDR` | `ST_HELD` | The last address byte is taken. |
| `T_NEXT` | `ST_HELD` | `ST_ADDR` | A start byte arrives. |

Top module: `mcast_hash_filter`

## Requirements
- R1: The CRC register starts at all ones. Each address byte is fed least-significant bit first. For each bit, when CRC bit 0 XOR the data bit is 1, the register shifts right and is XORed with 0xEDB88320; otherwise it only shifts right. No final inversion is applied. The hash is the 32-bit CRC shifted right by 26.
- R2: Hash bits [5:4] select the mask word (word n holds mask bits 16n..16n+15). Hash bits [3:0] select the bit within that word. With hash enabled, and all-multicast and promiscuous off, a group frame is accepted exactly when that mask bit is 1.
- R3: A frame is a group frame when bit 0 of its first address byte is 1. A non-group frame is rejected unless promiscuous mode is on, whatever the mask holds.
- R4: With promiscuous on, every frame is accepted.
- R5: With hash enabled and all-multicast on, every group frame is accepted, even with an all-zero mask.
- R6: With hash disabled and promiscuous off, group frames are rejected, even if all-multicast is set or the mask is all ones.
- R7: `decision_valid` rises on the edge that takes the sixth address byte. After that, `decision_valid` and `decision_accept` hold through later bytes until a start byte, which clears `decision_valid` on its own edge.
- R8: Mask writes take effect only while `rx_en` is low, and are ignored while it is high. Bytes are ignored while `rx_en` is low. Dropping `rx_en` mid-address abandons the frame, so no verdict appears.
- R9: After reset, `decision_valid` is 0 and all mask words are zero.
- R10: A start byte during address collection discards the partial address and begins a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable; low unlocks mask writes |
| hash_en | input | 1 | Group hash filtering enable |
| all_multi | input | 1 | Treat mask as all ones |
| promisc | input | 1 | Accept every frame |
| mask_wr_en | input | 1 | Mask word write strobe |
| mask_wr_sel | input | 2 | Mask word index |
| mask_wr_data | input | 16 | Mask word value |
| byte_valid | input | 1 | Frame byte present |
| sof | input | 1 | Byte is the first of a frame |
| byte_data | input | 8 | Frame byte |
| decision_valid | output | 1 | Verdict published |
| decision_accept | output | 1 | Frame passes the filter |

## Verification
The bench builds the block with its default values: a six-byte address and four 16-bit mask words. That small mask makes the whole 64-entry index space cheap to cover. The bench streams 1024 group addresses under one mask pattern and then under its complement, so every hash position is almost certainly seen both set and clear. A coverage check confirms that all 64 positions were reached. Directed frames then cover the corner cases: mode combinations, the write lock, abort and restart.

// File: rtl/mhf_pkg.sv
`timescale 1ns/1ps
package mhf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_HELD = 2'd2
    } mhf_state_e;

    // One byte through a reflected CRC, bit 0 of the byte first.
    function automatic logic [31:0] crc_refl_byte(
        input logic [31:0] crc_in,
        input logic [7:0]  data,
        input logic [31:0] poly
    );
        logic [31:0] c;
        c = crc_in;
        for (int j = 0; j < 8; j++) begin
            if (c[0] ^ data[j]) c = (c >> 1) ^ poly;
            else                c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/mhf_crc_acc.sv
`timescale 1ns/1ps
module mhf_crc_acc #(
    parameter logic [31:0] POLY   = 32'hEDB88320,
    parameter int          HASH_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              step,
    input  logic [7:0]        data,
    output logic [HASH_W-1:0] hash_nx
);
    logic [31:0] crc_q;
    logic [31:0] seed;
    logic [31:0] crc_nx;

    always_comb begin
        seed   = start ? 32'hFFFF_FFFF : crc_q;
        crc_nx = mhf_pkg::crc_refl_byte(seed, data, POLY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    crc_q <= 32'hFFFF_FFFF;
        else if (step) crc_q <= crc_nx;
    end

    assign hash_nx = crc_nx[31 -: HASH_W];
endmodule

// File: rtl/mhf_mask_bank.sv
`timescale 1ns/1ps
module mhf_mask_bank #(
    parameter  int WORD_W     = 16,
    parameter  int MASK_WORDS = 4,
    localparam int SEL_W      = (MASK_WORDS > 1) ? $clog2(MASK_WORDS) : 1,
    localparam int MASK_BITS  = WORD_W * MASK_WORDS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_allow,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     wr_sel,
    input  logic [WORD_W-1:0]    wr_data,
    output logic [MASK_BITS-1:0] mask_flat
);
    for (genvar g = 0; g < MASK_WORDS; g++) begin : g_word
        logic [WORD_W-1:0] word_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word_q <= '0;
            else if (wr_allow && wr_en && (wr_sel == SEL_W'(g)))
                word_q <= wr_data;
        end

        assign mask_flat[g*WORD_W +: WORD_W] = word_q;
    end
endmodule

// File: rtl/mhf_verdict.sv
`timescale 1ns/1ps
module mhf_verdict #(
    parameter int MASK_BITS = 64,
    parameter int HASH_W    = 6
) (
    input  logic [MASK_BITS-1:0] mask_flat,
    input  logic [HASH_W-1:0]    hash,
    input  logic                 group,
    input  logic                 hash_en,
    input  logic                 all_multi,
    input  logic                 promisc,
    output logic                 accept
);
    logic mask_hit;
    logic group_pass;

    always_comb begin
        mask_hit   = mask_flat[hash];
        group_pass = group && hash_en && (all_multi || mask_hit);
        accept     = promisc || group_pass;
    end
endmodule

// File: rtl/mcast_hash_filter.sv
`timescale 1ns/1ps
module mcast_hash_filter #(
    parameter  int          ADDR_BYTES = 6,
    parameter  int          WORD_W     = 16,
    parameter  int          MASK_WORDS = 4,
    parameter  logic [31:0] CRC_POLY   = 32'hEDB88320,
    localparam int          SEL_W      = (MASK_WORDS > 1) ? $clog2(MASK_WORDS) : 1,
    localparam int          MASK_BITS  = WORD_W * MASK_WORDS,
    localparam int          HASH_W     = $clog2(MASK_BITS),
    localparam int          CNT_W      = $clog2(ADDR_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              hash_en,
    input  logic              all_multi,
    input  logic              promisc,
    input  logic              mask_wr_en,
    input  logic [SEL_W-1:0]  mask_wr_sel,
    input  logic [WORD_W-1:0] mask_wr_data,
    input  logic              byte_valid,
    input  logic              sof,
    input  logic [7:0]        byte_data,
    output logic              decision_valid,
    output logic              decision_accept
);
    import mhf_pkg::*;

    mhf_state_e         state_q, state_d;
    logic [CNT_W-1:0]   cnt_q;
    logic               group_q;
    logic               take, is_sof, addr_byte, last_byte, crc_step;
    logic [HASH_W-1:0]  hash_nx;
    logic [MASK_BITS-1:0] mask_flat;
    logic               verdict;

    always_comb begin
        take      = byte_valid && rx_en;
        is_sof    = take && sof;
        addr_byte = (state_q == ST_ADDR) && take && !sof;
        last_byte = addr_byte && (cnt_q == CNT_W'(ADDR_BYTES - 1));
        crc_step  = is_sof || addr_byte;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (is_sof) state_d = ST_ADDR;           // T_START
            ST_ADDR: begin
                if (!rx_en)         state_d = ST_IDLE;        // T_ABORT
                else if (is_sof)    state_d = ST_ADDR;        // T_RESTART
                else if (last_byte) state_d = ST_HELD;        // T_DECIDE
            end
            ST_HELD: if (is_sof) state_d = ST_ADDR;           // T_NEXT
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and address bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            group_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (is_sof) begin
                cnt_q   <= CNT_W'(1);
                group_q <= byte_data[0];
            end else if (addr_byte) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            decision_valid  <= 1'b0;
            decision_accept <= 1'b0;
        end else if (is_sof) begin
            decision_valid  <= 1'b0;
            decision_accept <= 1'b0;
        end else if (last_byte) begin
            decision_valid  <= 1'b1;
            decision_accept <= verdict;
        end
    end

    mhf_crc_acc #(
        .POLY   (CRC_POLY),
        .HASH_W (HASH_W)
    ) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (is_sof),
        .step    (crc_step),
        .data    (byte_data),
        .hash_nx (hash_nx)
    );

    mhf_mask_bank #(
        .WORD_W     (WORD_W),
        .MASK_WORDS (MASK_WORDS)
    ) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_allow  (!rx_en),
        .wr_en     (mask_wr_en),
        .wr_sel    (mask_wr_sel),
        .wr_data   (mask_wr_data),
        .mask_flat (mask_flat)
    );

    mhf_verdict #(
        .MASK_BITS (MASK_BITS),
        .HASH_W    (HASH_W)
    ) u_verdict (
        .mask_flat (mask_flat),
        .hash      (hash_nx),
        .group     (group_q),
        .hash_en   (hash_en),
        .all_multi (all_multi),
        .promisc   (promisc),
        .accept    (verdict)
    );
endmodule

// File: rtl/mcast_hash_filter_chk.sv
`timescale 1ns/1ps
module mcast_hash_filter_chk #(
    parameter int MASK_BITS = 64
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rx_en,
    input logic                 hash_en,
    input logic                 promisc,
    input logic                 byte_valid,
    input logic                 sof,
    input logic                 decision_valid,
    input logic                 decision_accept,
    input logic [MASK_BITS-1:0] mask_flat
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> !decision_valid); // R9

    AST_HOLD_UNTIL_SOF: assert property (@(posedge clk) disable iff (!rst_n)
        decision_valid && !(sof && byte_valid && rx_en)
        |=> decision_valid && $stable(decision_accept)); // R7

    AST_SOF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        sof && byte_valid && rx_en |=> !decision_valid); // R7

    AST_MASK_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en |=> $stable(mask_flat)); // R8

    AST_PROMISC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(decision_valid) && $past(promisc) |-> decision_accept); // R4

    AST_FILTER_OFF_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(decision_valid) && !$past(promisc) && !$past(hash_en)
        |-> !decision_accept); // R6
endmodule

bind mcast_hash_filter mcast_hash_filter_chk #(
    .MASK_BITS (WORD_W * MASK_WORDS)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .rx_en           (rx_en),
    .hash_en         (hash_en),
    .promisc         (promisc),
    .byte_valid      (byte_valid),
    .sof             (sof),
    .decision_valid  (decision_valid),
    .decision_accept (decision_accept),
    .mask_flat       (mask_flat)
);

// File: tb/mcast_hash_filter_tb.sv
`timescale 1ns/1ps
module mcast_hash_filter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b0, hash_en = 1'b0, all_multi = 1'b0, promisc = 1'b0;
    logic        mask_wr_en = 1'b0;
    logic [1:0]  mask_wr_sel = '0;
    logic [15:0] mask_wr_data = '0;
    logic        byte_valid = 1'b0, sof = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        decision_valid, decision_accept;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [63:0] seen;

    always #4 clk = ~clk;

    mcast_hash_filter u_dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .hash_en(hash_en),
        .all_multi(all_multi), .promisc(promisc), .mask_wr_en(mask_wr_en),
        .mask_wr_sel(mask_wr_sel), .mask_wr_data(mask_wr_data),
        .byte_valid(byte_valid), .sof(sof), .byte_data(byte_data),
        .decision_valid(decision_valid), .decision_accept(decision_accept)
    );

    // Software model: reflected CRC, LSB first, preset ones, hash = crc >> 26.
    function automatic logic [5:0] model_hash(input logic [47:0] a);
        logic [31:0] crc = 32'hFFFF_FFFF;
        for (int i = 0; i < 6; i++)
            for (int j = 0; j < 8; j++) begin
                logic t;
                t = crc[0] ^ a[8*i + j];
                crc = crc >> 1;
                if (t) crc = crc ^ 32'hEDB88320;
            end
        return 6'(crc >> 26);
    endfunction

    task automatic check(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0b expected=%0b", req, got, exp);
        end
    endtask

    task automatic write_mask(input logic [63:0] m);
        for (int w = 0; w < 4; w++) begin
            @(negedge clk);
            mask_wr_en = 1'b1; mask_wr_sel = 2'(w); mask_wr_data = m[16*w +: 16];
        end
        @(negedge clk);
        mask_wr_en = 1'b0;
    endtask

    // Byte 0 of the address is a[7:0]. Returns sampled at the negedge after the last byte.
    task automatic send_bytes(input logic [47:0] a, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            byte_valid = 1'b1; sof = (i == 0); byte_data = a[8*i +: 8];
        end
        @(negedge clk);
        byte_valid = 1'b0; sof = 1'b0;
    endtask

    task automatic set_cfg(input logic en, input logic he, input logic am, input logic pr);
        @(negedge clk);
        rx_en = en; hash_en = he; all_multi = am; promisc = pr;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    initial begin
        logic [63:0] pat;
        logic [47:0] a, b;
        logic [5:0]  h;
        repeat (3) @(negedge clk);
        check("R9 valid low in reset", decision_valid, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 valid low after reset", decision_valid, 1'b0);

        // R9: mask cleared by reset -> group frames rejected
        set_cfg(1, 1, 0, 0);
        for (int k = 0; k < 8; k++) begin
            send_bytes({8'(k*37), 8'(k), 8'h00, 8'h5E, 8'h00, 8'h01}, 6);
            check("R9 zero mask rejects", decision_accept, 1'b0);
        end

        // R1/R2 sweep with a pattern and its complement
        seen = '0;
        for (int p = 0; p < 2; p++) begin
            pat = (p == 0) ? 64'hA5C3_0F96_3C5A_F00F : ~64'hA5C3_0F96_3C5A_F00F;
            set_cfg(0, 1, 0, 0);
            write_mask(pat);
            set_cfg(1, 1, 0, 0);
            for (int k = 0; k < 1024; k++) begin
                a = {8'(k), 8'(k >> 8) ^ 8'h3C, 8'h11, 8'h5E, 8'h00, 8'h01};
                h = model_hash(a);
                seen[h] = 1'b1;
                send_bytes(a, 6);
                check("R7 valid after sixth byte", decision_valid, 1'b1);
                check("R1 R2 hash bit select", decision_accept, pat[h]);
            end
        end
        check("R1 all 64 hash positions covered", &seen, 1'b1);

        // R3: non-group rejected with all-ones mask
        set_cfg(0, 1, 0, 0);
        write_mask('1);
        set_cfg(1, 1, 0, 0);
        send_bytes(48'h0000_0000_1200, 6);
        check("R3 unicast rejected", decision_accept, 1'b0);
        send_bytes(48'h0000_0000_1201, 6);
        check("R3 group with ones accepted", decision_accept, 1'b1);

        // R4: promiscuous accepts unicast with zero mask
        set_cfg(0, 0, 0, 1);
        write_mask('0);
        set_cfg(1, 0, 0, 1);
        send_bytes(48'h1234_5678_9A00, 6);
        check("R4 promisc unicast", decision_accept, 1'b1);
        send_bytes(48'h1234_5678_9A01, 6);
        check("R4 promisc group", decision_accept, 1'b1);

        // R5: all-multi overrides zero mask
        set_cfg(1, 1, 1, 0);
        send_bytes(48'hFFEE_DDCC_BB01, 6);
        check("R5 all-multi group", decision_accept, 1'b1);
        send_bytes(48'hFFEE_DDCC_BB00, 6);
        check("R3 all-multi unicast", decision_accept, 1'b0);

        // R6: hash disabled rejects groups
        set_cfg(1, 0, 1, 0);
        send_bytes(48'hFFEE_DDCC_BB01, 6);
        check("R6 hash off all-multi", decision_accept, 1'b0);
        set_cfg(0, 0, 0, 0);
        write_mask('1);
        set_cfg(1, 0, 0, 0);
        send_bytes(48'h0102_0304_0501, 6);
        check("R6 hash off ones mask", decision_accept, 1'b0);

        // R7: hold through trailing bytes, cleared by sof
        set_cfg(1, 1, 0, 0);
        send_bytes(48'h0102_0304_0501, 6);
        check("R7 accept before trailer", decision_accept, 1'b1);
        send_bytes(48'h0000_0000_0000, 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); byte_valid = 1'b1; sof = 1'b0; byte_data = 8'(i);
        end
        @(negedge clk); byte_valid = 1'b0;
        check("R7 valid held", decision_valid, 1'b1);
        check("R7 accept held", decision_accept, 1'b1);
        send_bytes(48'h0102_0304_0501, 1);
        check("R7 sof clears valid", decision_valid, 1'b0);

        // R8: abort mid-address, bytes ignored while disabled
        set_cfg(0, 1, 0, 0);
        send_bytes(48'h0102_0304_0501, 6);
        check("R8 abort gives no verdict", decision_valid, 1'b0);

        // R8: writes ignored while enabled
        write_mask('0);
        set_cfg(1, 1, 0, 0);
        write_mask('1);
        send_bytes(48'h0102_0304_0501, 6);
        check("R8 locked write ignored", decision_accept, 1'b0);
        set_cfg(0, 1, 0, 0);
        write_mask('1);
        set_cfg(1, 1, 0, 0);
        send_bytes(48'h0102_0304_0501, 6);
        check("R8 unlocked write applied", decision_accept, 1'b1);

        // R10: restart mid-address
        b = 48'h0A0B_0C0D_0E01;
        a = 48'h5544_3322_1101;
        h = model_hash(b);
        pat = 64'h1 << h;
        if (model_hash(a) == h) a = 48'h5544_3322_1103;
        set_cfg(0, 1, 0, 0);
        write_mask(pat);
        set_cfg(1, 1, 0, 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); byte_valid = 1'b1; sof = (i == 0); byte_data = a[8*i +: 8];
        end
        send_bytes(b, 6);
        check("R10 restart valid", decision_valid, 1'b1);
        check("R10 restart uses new address", decision_accept, 1'b1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule